// File: doc/BRIEF.md
# Configurable Time-Division System Multiplexer

This block sits between eight per-channel serial streams and the system-side ports of a multi-channel line interface. In the receive direction it interleaves the channel data and signalling bits onto the system ports by time-division phase. In the transmit direction it takes data and signalling bits from the system ports and hands each bit back to the channel that owns the current phase. A free-running phase counter advances once per system clock. A frame sync input pulls it back to phase 0, so phase 0 lines up with the start of a system frame.

Two mode inputs pick one of three topologies. The octal topology carries all eight channels on port 1, one channel per phase. The slow dual topology splits the channels into two groups of four: channels 0–3 go on port 1 and channels 4–7 go on port 5. Each channel keeps its bit for two phases, which gives half the rate. The fast dual topology uses the same two groups. Port 1 is active only in phases 0–3 and port 5 only in phases 4–7. In its idle phases each of these ports drives a low level, so a board-level wired OR of the two ports rebuilds the full eight-phase stream. Ports that carry nothing have their output enable deasserted. Ports are numbered from 1 in the text and from 0 in the vectors, so port 1 is index 0 and port 5 is index 4.

Top module: `tdm_sys_mux`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the phase is 0, every `ch_tx_stb` bit is 0 and every `ch_tx_data` bit is 0.
- R2: With `mode_octal`=1, `sys_rdo[0]` equals `ch_rx_data[k]` in phase k (k = 0..7), and `sys_oe[0]` is 1.
- R3: With `mode_octal`=1 every port other than index 0 has `sys_oe`=0 and `sys_rdo`=0. In both dual topologies every port other than indices 0 and 4 has `sys_oe`=0 and `sys_rdo`=0.
- R4: With `mode_octal`=0 and `mode_dual_fast`=0, in phase k `sys_rdo[0]` carries channel k/2 (integer division) and `sys_rdo[4]` carries channel 4+k/2. Both `sys_oe[0]` and `sys_oe[4]` are 1.
- R5: With `mode_octal`=0 and `mode_dual_fast`=1, `sys_rdo[0]` carries channel k in phases 0–3 and `sys_rdo[4]` carries channel k in phases 4–7. The two ports are never both high.
- R6: In the fast dual topology, a port in its idle phases drives 0 with `sys_oe` held at 1. The OR of `sys_rdo[0]` and `sys_rdo[4]` in phase k equals `ch_rx_data[k]`.
- R7: `mode_octal`=1 selects the octal topology whatever the value of `mode_dual_fast`.
- R8: `sys_rsig` follows exactly the same port and phase mapping as `sys_rdo`, fed from `ch_rx_sig`.
- R9: Each channel captures `sys_xdi`/`sys_xsig` from the port that owns it in the phase (octal, fast dual), or in the second phase of its phase pair (slow dual), where receive data would place it. The capture shows on `ch_tx_data`/`ch_tx_sig` one cycle later, with a one-cycle `ch_tx_stb` pulse. At other times the held value does not change.
- R10: When `fsync` is high at a clock edge, the phase after that edge is 0. Otherwise the phase advances by one per clock and wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; forces the next phase to 0 |
| mode_octal | input | 1 | 1: 8-to-1 on port 1; 0: dual 4-to-1 topologies |
| mode_dual_fast | input | 1 | In dual topologies, 1: disjoint-phase (wired-OR) variant, 0: half-rate variant |
| ch_rx_data | input | 8 | Receive data bit per channel |
| ch_rx_sig | input | 8 | Receive signalling bit per channel |
| sys_rdo | output | 8 | Receive data per system port |
| sys_rsig | output | 8 | Receive signalling per system port |
| sys_oe | output | 8 | Output enable per system port (0 = high impedance) |
| sys_xdi | input | 8 | Transmit data per system port |
| sys_xsig | input | 8 | Transmit signalling per system port |
| ch_tx_data | output | 8 | Demultiplexed transmit data per channel, held |
| ch_tx_sig | output | 8 | Demultiplexed transmit signalling per channel, held |
| ch_tx_stb | output | 8 | One-cycle pulse when a channel's transmit bits update |

## Verification
Some properties are checked on every cycle. The phase must align after frame sync and step by one otherwise. Unused ports must stay disabled and idle-low. The two fast-dual ports must never be high together. No more than one channel may be strobed outside the slow dual topology, and held transmit values must not change without a strobe. Only the scoreboard scenarios can show that the right channel reaches the right port in each phase for all three topologies. They also show that signalling tracks data, that the wired OR rebuilds the eight-channel stream, that the octal bit overrides the fast bit, and that transmit bits reach the right channels after mode changes and a mid-frame sync.

// File: rtl/tdm_sys_pkg.sv
package tdm_sys_pkg;

   typedef enum logic [1:0] {
      TOPO_OCTAL     = 2'd0,
      TOPO_DUAL_SLOW = 2'd1,
      TOPO_DUAL_FAST = 2'd2
   } topo_e;

   // The octal bit overrides the fast bit (R7)
   function automatic topo_e decode_topo(input logic octal, input logic fast);
      if (octal)
         return TOPO_OCTAL;
      else if (fast)
         return TOPO_DUAL_FAST;
      else
         return TOPO_DUAL_SLOW;
   endfunction

endpackage

// File: rtl/tdm_phase_gen.sv
module tdm_phase_gen #(
   parameter int N_PH = 8,
   localparam int PH_W = $clog2(N_PH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fsync,
   output logic [PH_W-1:0] ph_q
);

   initial begin
      assert (N_PH >= 4 && (N_PH & (N_PH - 1)) == 0)
         else $error("tdm_phase_gen: N_PH must be a power of two >= 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_q <= '0;
      else if (fsync)
         ph_q <= '0;
      else
         ph_q <= ph_q + PH_W'(1);
   end

   AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> (ph_q == '0)); // R10

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !fsync |=> (ph_q == $past(ph_q) + PH_W'(1))); // R10

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
   import tdm_sys_pkg::*;
#(
   parameter int N_CH = 8,
   localparam int PH_W = $clog2(N_CH),
   localparam int GRP  = N_CH / 2
) (
   input  topo_e           topo,
   input  logic [PH_W-1:0] ph,
   output logic            a_act,
   output logic [PH_W-1:0] a_ch,
   output logic            a_cap,
   output logic            b_act,
   output logic [PH_W-1:0] b_ch,
   output logic            b_cap
);

   logic [PH_W-1:0] half_ph;
   logic            low_half;

   assign half_ph  = ph >> 1;
   assign low_half = (ph < PH_W'(GRP));

   always_comb begin
      a_act = 1'b0;
      a_ch  = '0;
      a_cap = 1'b0;
      b_act = 1'b0;
      b_ch  = '0;
      b_cap = 1'b0;
      unique case (topo)
         TOPO_OCTAL: begin
            a_act = 1'b1;
            a_ch  = ph;
            a_cap = 1'b1;
         end
         TOPO_DUAL_SLOW: begin
            a_act = 1'b1;
            a_ch  = half_ph;
            a_cap = ph[0];
            b_act = 1'b1;
            b_ch  = half_ph + PH_W'(GRP);
            b_cap = ph[0];
         end
         TOPO_DUAL_FAST: begin
            a_act = low_half;
            a_ch  = ph;
            a_cap = low_half;
            b_act = !low_half;
            b_ch  = ph;
            b_cap = !low_half;
         end
         default: begin
            a_act = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/tdm_rx_mux.sv
module tdm_rx_mux
   import tdm_sys_pkg::*;
#(
   parameter int N_CH   = 8,
   parameter int PORT_A = 0,
   parameter int PORT_B = 4,
   localparam int PH_W  = $clog2(N_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  topo_e           topo,
   input  logic            a_act,
   input  logic [PH_W-1:0] a_ch,
   input  logic            b_act,
   input  logic [PH_W-1:0] b_ch,
   input  logic [N_CH-1:0] rx_data,
   input  logic [N_CH-1:0] rx_sig,
   output logic [N_CH-1:0] rdo,
   output logic [N_CH-1:0] rsig,
   output logic [N_CH-1:0] oe
);

   initial begin
      assert (PORT_A != PORT_B && PORT_A < N_CH && PORT_B < N_CH)
         else $error("tdm_rx_mux: ports must be distinct and in range");
   end

   for (genvar p = 0; p < N_CH; p++) begin : g_port
      if (p == PORT_A) begin : g_first
         assign rdo[p]  = a_act ? rx_data[a_ch] : 1'b0;
         assign rsig[p] = a_act ? rx_sig[a_ch]  : 1'b0;
         assign oe[p]   = 1'b1;
      end else if (p == PORT_B) begin : g_second
         assign rdo[p]  = b_act ? rx_data[b_ch] : 1'b0;
         assign rsig[p] = b_act ? rx_sig[b_ch]  : 1'b0;
         assign oe[p]   = (topo != TOPO_OCTAL);
      end else begin : g_idle
         assign rdo[p]  = 1'b0;
         assign rsig[p] = 1'b0;
         assign oe[p]   = 1'b0;
      end
   end

   localparam logic [N_CH-1:0] USED = (N_CH'(1) << PORT_A) | (N_CH'(1) << PORT_B);

   AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((oe & ~USED) == '0) && ((rdo & ~USED) == '0)); // R3

   AST_OCTAL_SECOND_Z: assert property (@(posedge clk) disable iff (!rst_n)
      (topo == TOPO_OCTAL) |-> (!oe[PORT_B] && !rdo[PORT_B])); // R3

   AST_FAST_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      (topo == TOPO_DUAL_FAST) |-> !(rdo[PORT_A] && rdo[PORT_B])); // R5

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (topo == TOPO_DUAL_FAST && !a_act) |-> (oe[PORT_A] && !rdo[PORT_A] && !rsig[PORT_A])); // R6

endmodule

// File: rtl/tdm_tx_demux.sv
module tdm_tx_demux
   import tdm_sys_pkg::*;
#(
   parameter int N_CH = 8,
   localparam int PH_W = $clog2(N_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  topo_e           topo,
   input  logic            a_cap,
   input  logic [PH_W-1:0] a_ch,
   input  logic            b_cap,
   input  logic [PH_W-1:0] b_ch,
   input  logic            a_xdi,
   input  logic            a_xsig,
   input  logic            b_xdi,
   input  logic            b_xsig,
   output logic [N_CH-1:0] tx_data,
   output logic [N_CH-1:0] tx_sig,
   output logic [N_CH-1:0] tx_stb
);

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      logic hit_a;
      logic hit_b;

      assign hit_a = a_cap && (a_ch == PH_W'(k));
      assign hit_b = b_cap && (b_ch == PH_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_data[k] <= 1'b0;
            tx_sig[k]  <= 1'b0;
            tx_stb[k]  <= 1'b0;
         end else begin
            tx_stb[k] <= hit_a || hit_b;
            if (hit_a) begin
               tx_data[k] <= a_xdi;
               tx_sig[k]  <= a_xsig;
            end else if (hit_b) begin
               tx_data[k] <= b_xdi;
               tx_sig[k]  <= b_xsig;
            end
         end
      end

      AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
         !tx_stb[k] |-> ($stable(tx_data[k]) && $stable(tx_sig[k]))); // R9
   end

   AST_SINGLE_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (topo != TOPO_DUAL_SLOW) |=> ($countones(tx_stb) <= 1)); // R9

endmodule

// File: rtl/tdm_sys_mux.sv
module tdm_sys_mux
   import tdm_sys_pkg::*;
#(
   parameter int N_CH   = 8,
   parameter int PORT_A = 0,
   parameter int PORT_B = N_CH / 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fsync,
   input  logic            mode_octal,
   input  logic            mode_dual_fast,
   input  logic [N_CH-1:0] ch_rx_data,
   input  logic [N_CH-1:0] ch_rx_sig,
   output logic [N_CH-1:0] sys_rdo,
   output logic [N_CH-1:0] sys_rsig,
   output logic [N_CH-1:0] sys_oe,
   input  logic [N_CH-1:0] sys_xdi,
   input  logic [N_CH-1:0] sys_xsig,
   output logic [N_CH-1:0] ch_tx_data,
   output logic [N_CH-1:0] ch_tx_sig,
   output logic [N_CH-1:0] ch_tx_stb
);

   localparam int PH_W = $clog2(N_CH);

   initial begin
      assert (N_CH >= 4 && (N_CH & (N_CH - 1)) == 0)
         else $error("tdm_sys_mux: N_CH must be a power of two >= 4");
   end

   topo_e           topo;
   logic [PH_W-1:0] ph_q;
   logic            a_act;
   logic            a_cap;
   logic            b_act;
   logic            b_cap;
   logic [PH_W-1:0] a_ch;
   logic [PH_W-1:0] b_ch;

   assign topo = decode_topo(mode_octal, mode_dual_fast);

   tdm_phase_gen #(.N_PH(N_CH)) i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .fsync (fsync),
      .ph_q  (ph_q)
   );

   tdm_slot_map #(.N_CH(N_CH)) i_map (
      .topo  (topo),
      .ph    (ph_q),
      .a_act (a_act),
      .a_ch  (a_ch),
      .a_cap (a_cap),
      .b_act (b_act),
      .b_ch  (b_ch),
      .b_cap (b_cap)
   );

   tdm_rx_mux #(.N_CH(N_CH), .PORT_A(PORT_A), .PORT_B(PORT_B)) i_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .topo    (topo),
      .a_act   (a_act),
      .a_ch    (a_ch),
      .b_act   (b_act),
      .b_ch    (b_ch),
      .rx_data (ch_rx_data),
      .rx_sig  (ch_rx_sig),
      .rdo     (sys_rdo),
      .rsig    (sys_rsig),
      .oe      (sys_oe)
   );

   tdm_tx_demux #(.N_CH(N_CH)) i_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .topo    (topo),
      .a_cap   (a_cap),
      .a_ch    (a_ch),
      .b_cap   (b_cap),
      .b_ch    (b_ch),
      .a_xdi   (sys_xdi[PORT_A]),
      .a_xsig  (sys_xsig[PORT_A]),
      .b_xdi   (sys_xdi[PORT_B]),
      .b_xsig  (sys_xsig[PORT_B]),
      .tx_data (ch_tx_data),
      .tx_sig  (ch_tx_sig),
      .tx_stb  (ch_tx_stb)
   );

   AST_OCTAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_octal |-> (sys_oe[PORT_A] && !sys_oe[PORT_B])); // R7

endmodule

// File: tb/test_tdm_sys_mux.sv
module test_tdm_sys_mux;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync = 1'b0;
   logic       mode_octal = 1'b1;
   logic       mode_dual_fast = 1'b0;
   logic [7:0] ch_rx_data = '0;
   logic [7:0] ch_rx_sig = '0;
   logic [7:0] sys_xdi = '0;
   logic [7:0] sys_xsig = '0;
   logic [7:0] sys_rdo, sys_rsig, sys_oe;
   logic [7:0] ch_tx_data, ch_tx_sig, ch_tx_stb;

   always #10 clk = ~clk; // 50 MHz

   tdm_sys_mux i_tdm_sys_mux (
      .clk            (clk),
      .rst_n          (rst_n),
      .fsync          (fsync),
      .mode_octal     (mode_octal),
      .mode_dual_fast (mode_dual_fast),
      .ch_rx_data     (ch_rx_data),
      .ch_rx_sig      (ch_rx_sig),
      .sys_rdo        (sys_rdo),
      .sys_rsig       (sys_rsig),
      .sys_oe         (sys_oe),
      .sys_xdi        (sys_xdi),
      .sys_xsig       (sys_xsig),
      .ch_tx_data     (ch_tx_data),
      .ch_tx_sig      (ch_tx_sig),
      .ch_tx_stb      (ch_tx_stb)
   );

   typedef struct {
      logic [7:0] rdo;
      logic [7:0] rsig;
      logic [7:0] oe;
      logic [7:0] xd;
      logic [7:0] xs;
      logic [7:0] xstb;
      logic       or_chk;
      logic       or_exp;
      string      tag;
   } exp_t;

   exp_t       sbq[$];
   int         checks = 0;
   int         failures = 0;
   int         cnt = 0;
   logic [2:0] ph_m = '0;
   logic [7:0] m_xd = '0, m_xs = '0, m_stb = '0;
   bit         done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Driver: sets inputs for one phase, pushes the expected item, advances the model
   task automatic drive(input bit fs, input bit oct, input bit fast, input string tag);
      exp_t e;
      int   k;
      cnt++;
      fsync          = fs;
      mode_octal     = oct;
      mode_dual_fast = fast;
      ch_rx_data     = 8'(cnt * 29) ^ 8'hA5;
      ch_rx_sig      = 8'(cnt * 53) ^ 8'h3C;
      sys_xdi        = 8'(cnt * 13 + 7);
      sys_xsig       = 8'(cnt * 71) ^ 8'h96;
      e.rdo = '0; e.rsig = '0; e.oe = '0; e.or_chk = 0; e.or_exp = 0; e.tag = tag;
      if (oct) begin
         e.oe[0]   = 1'b1;
         e.rdo[0]  = ch_rx_data[ph_m];
         e.rsig[0] = ch_rx_sig[ph_m];
      end else if (!fast) begin
         k = int'(ph_m) / 2;
         e.oe[0] = 1'b1; e.oe[4] = 1'b1;
         e.rdo[0]  = ch_rx_data[k];     e.rsig[0] = ch_rx_sig[k];
         e.rdo[4]  = ch_rx_data[k + 4]; e.rsig[4] = ch_rx_sig[k + 4];
      end else begin
         e.oe[0] = 1'b1; e.oe[4] = 1'b1;
         if (ph_m < 3'd4) begin
            e.rdo[0] = ch_rx_data[ph_m]; e.rsig[0] = ch_rx_sig[ph_m];
         end else begin
            e.rdo[4] = ch_rx_data[ph_m]; e.rsig[4] = ch_rx_sig[ph_m];
         end
         e.or_chk = 1; e.or_exp = ch_rx_data[ph_m];
      end
      e.xd = m_xd; e.xs = m_xs; e.xstb = m_stb;
      sbq.push_back(e);
      @(posedge clk);
      m_stb = '0;
      if (oct) begin
         m_xd[ph_m] = sys_xdi[0]; m_xs[ph_m] = sys_xsig[0]; m_stb[ph_m] = 1'b1;
      end else if (!fast) begin
         if (ph_m[0]) begin
            k = int'(ph_m) / 2;
            m_xd[k] = sys_xdi[0];     m_xs[k] = sys_xsig[0];     m_stb[k] = 1'b1;
            m_xd[k + 4] = sys_xdi[4]; m_xs[k + 4] = sys_xsig[4]; m_stb[k + 4] = 1'b1;
         end
      end else begin
         if (ph_m < 3'd4) begin
            m_xd[ph_m] = sys_xdi[0]; m_xs[ph_m] = sys_xsig[0];
         end else begin
            m_xd[ph_m] = sys_xdi[4]; m_xs[ph_m] = sys_xsig[4];
         end
         m_stb[ph_m] = 1'b1;
      end
      ph_m = fs ? 3'd0 : ph_m + 3'd1;
      #1;
   endtask

   // Monitor: pops one expected item per cycle and compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check((sys_rdo & 8'h11) == e.rdo && (sys_oe & 8'h11) == (e.oe & 8'h11),
                  e.tag, "rdo", sys_rdo, e.rdo);
            check((sys_oe & 8'hEE) == 8'h00 && (sys_rdo & 8'hEE) == 8'h00 && sys_oe == e.oe,
                  "R3", "oe", sys_oe, e.oe);
            check(sys_rsig == e.rsig, "R8", "rsig", sys_rsig, e.rsig);
            check(ch_tx_data == e.xd && ch_tx_sig == e.xs, "R9", "tx_data", ch_tx_data, e.xd);
            check(ch_tx_stb == e.xstb, "R9", "tx_stb", ch_tx_stb, e.xstb);
            if (e.or_chk)
               check((sys_rdo[0] | sys_rdo[4]) == e.or_exp, "R6", "wired_or",
                     {7'd0, sys_rdo[0] | sys_rdo[4]}, {7'd0, e.or_exp});
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      ch_rx_data = 8'h01;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: in reset, phase 0 puts channel 0 on port index 0, no strobes, cleared data
      check(ch_tx_stb == 8'h00 && ch_tx_data == 8'h00, "R1", "reset_tx", ch_tx_stb, 8'h00);
      check(sys_rdo == 8'h01 && sys_oe == 8'h01, "R1", "reset_phase", sys_rdo, 8'h01);
      @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: first cycle after release is phase 0 (checked via scoreboard with R1 tag)
      drive(0, 1, 0, "R1");
      for (int i = 0; i < 18; i++) drive(0, 1, 0, "R2");
      // R10: mid-frame sync, then wrap through a full frame
      drive(1, 1, 0, "R10");
      for (int i = 0; i < 12; i++) drive(0, 1, 0, "R10");
      // R7: octal bit overrides fast bit
      for (int i = 0; i < 12; i++) drive(0, 1, 1, "R7");
      // R4: slow dual, realign first
      drive(1, 0, 0, "R4");
      for (int i = 0; i < 20; i++) drive(0, 0, 0, "R4");
      // R5/R6: fast dual
      drive(1, 0, 1, "R5");
      for (int i = 0; i < 20; i++) drive(0, 0, 1, "R5");
      // mode change without sync, then mid-frame sync in fast dual
      for (int i = 0; i < 5; i++) drive(0, 0, 0, "R4");
      drive(1, 0, 1, "R10");
      for (int i = 0; i < 10; i++) drive(0, 0, 1, "R5");
      for (int i = 0; i < 10; i++) drive(0, 1, 0, "R2");
      @(negedge clk);
      #1;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule